// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block takes a left/right pair of 20-bit two's-complement audio samples through a valid/ready handshake and sends them on a serial audio link. The link has a bit clock, a frame (channel) clock, a data-window strobe and one data line. A half-frame holds 32 bit-clock periods, so the bit clock runs at 64 times the frame rate. The sample's 20 bits go out most significant bit first, and the rest of each half-frame is filled with zeros. Data changes only on the falling edge of the bit clock.

A two-bit mode input sets the direction of the clocks and the data format. As a clock master, the block divides its system clock, which is the audio master clock at 256 or 384 times the frame rate, to make the bit clock, the frame clock and a strobe at twice the frame rate. As a clock slave, it samples the incoming bit clock, frame clock and strobe in its own clock domain and realigns its slot counter on every frame-clock transition. A new sample pair is picked up at the start of each frame; with no new pair, the last one is sent again. A power-down input holds the outputs at fixed rest levels and restarts the clock generator.

Top module: `stereo_ser_port`

## Requirements
- R1: In master mode (mode_sel[0]=1), sclk_out has a period of 4 clk cycles when ratio_sel=0 and 6 clk cycles when ratio_sel=1, with 50 % duty. lrck_out, fsync_out and sdata change only in the cycle in which sclk_out falls.
- R2: In master mode a frame is 64 sclk_out periods, counted as slots 0 to 63 from the falling edge at which lrck_out takes the left level. lrck_out holds the left level for slots 0 to 31 and the opposite level for slots 32 to 63. fsync_out is high in slots 0 to 15 and 32 to 47 and low elsewhere.
- R3: Frame-clock polarity: with mode_sel[1]=0 the left channel is marked by the frame clock high, and with mode_sel[1]=1 by the frame clock low.
- R4: In every mode except mode_sel=2'b00, each half-frame puts 0 in slot 0, the 20 sample bits MSB first in slots 1 to 20, and 0 in slots 21 to 31. The left sample goes in the left half and the right sample in the right half.
- R5: In mode_sel=2'b00 (slave, MSB-justified), the next sample bit, starting with the MSB at slot 0, is put out at a bit-clock fall only if fsync_in is high at that fall. At a fall with fsync_in low, sdata is 0 and no bit is used up. Once 20 bits have gone out, sdata stays 0 for the rest of the half-frame.
- R6: In slave mode (mode_sel[0]=0), a change of lrck_in seen at a falling edge of sclk_in restarts the slot count at slot 0 of the half that the new level marks. sdata settles within 4 clk cycles of the sclk_in fall. In mode_sel=2'b10, fsync_in has no effect on sdata.
- R7: In slave mode, sclk_out, lrck_out and fsync_out are held at 0.
- R8: While pwr_dn=1, sdata, sclk_out and fsync_out are 0 from the next cycle on. In master mode lrck_out then rests at the left level. After pwr_dn falls, the first sclk_out fall comes one full divide period later and starts slot 0 of a left half.
- R9: s_ready is 1 exactly when the one-pair holding register is empty. A pair taken in is sent from the next frame start on. Frames with no new pair repeat the last pair sent.
- R10: During rst=1 the block drives sdata, sclk_out and fsync_out to 0 and s_ready to 1, and lrck_out rests at the left level in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, equal to the audio master clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Power-down, active high |
| mode_sel | input | 2 | Bit 0: clock master; bit 1: left marked by frame clock low |
| ratio_sel | input | 1 | Master clock ratio: 0 = 256x frame rate, 1 = 384x |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding register empty, pair accepted |
| s_left | input | 20 | Left sample, two's complement |
| s_right | input | 20 | Right sample, two's complement |
| sclk_in | input | 1 | Bit clock from the link master (slave mode) |
| lrck_in | input | 1 | Frame clock from the link master (slave mode) |
| fsync_in | input | 1 | Data-window strobe (slave MSB-justified mode) |
| sclk_out | output | 1 | Generated bit clock (master mode) |
| lrck_out | output | 1 | Generated frame clock (master mode) |
| fsync_out | output | 1 | Generated strobe at twice the frame rate (master mode) |
| sdata | output | 1 | Serial audio data |

## Verification
The hardest case to reach from the ports is a slave link in which the frame clock and the data strobe do not line up with where the counter expects them. The counter has to realign, and the strobe has to hold back bits without losing them. The bench drives the incoming bit clock, frame clock and strobe itself, one slot at a time. It first sends a partial frame on the wrong channel level, so that the next frame-clock change must pull the count back to slot 0. It then drops the strobe for chosen slots in the middle of the sample in both halves, and checks that the held-back bits come out later, still in order. Master-mode frames are taken from the first right-to-left frame-clock change, so that sample latching, pair repetition and power-down restart are each checked on whole frames.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // mode_sel bit meanings
  localparam int MODE_MASTER_BIT = 0;
  localparam int MODE_POL_BIT    = 1;

  // level of the frame clock that marks the left channel
  function automatic logic left_level(input logic [1:0] mode);
    return ~mode[MODE_POL_BIT];
  endfunction

  // MSB-justified format only in slave mode with polarity bit clear
  function automatic logic is_msb_just(input logic [1:0] mode);
    return (mode == 2'b00);
  endfunction
endpackage

// File: rtl/ssp_master_gen.sv
module ssp_master_gen #(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd,
  input  logic              en,
  input  logic              ratio_hi,
  input  logic              left_lvl,
  output logic              tick,
  output logic [SLOT_W:0]   nslot,
  output logic              sclk_o,
  output logic              lrck_o,
  output logic              fsync_o
);
  localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int CNT_W   = $clog2(DIV_MAX);

  logic [CNT_W-1:0]  dcnt;
  logic [CNT_W-1:0]  div_last;
  logic [CNT_W-1:0]  rise_pt;
  logic [SLOT_W:0]   bcnt;
  logic              hold;

  assign div_last = ratio_hi ? CNT_W'(DIV_HI - 1)     : CNT_W'(DIV_LO - 1);
  assign rise_pt  = ratio_hi ? CNT_W'(DIV_HI / 2 - 1) : CNT_W'(DIV_LO / 2 - 1);
  assign hold     = rst || pd || !en;
  // tick marks the cycle before the bit-clock fall; the fall and the
  // new slot take effect at the next edge
  assign tick     = !hold && (dcnt >= div_last);
  assign nslot    = bcnt + 1'b1;

  always_ff @(posedge clk) begin
    if (hold) begin
      dcnt    <= '0;
      bcnt    <= '1;
      sclk_o  <= 1'b0;
      fsync_o <= 1'b0;
      lrck_o  <= en ? left_lvl : 1'b0;
    end else if (tick) begin
      dcnt    <= '0;
      bcnt    <= nslot;
      sclk_o  <= 1'b0;
      lrck_o  <= nslot[SLOT_W] ? ~left_lvl : left_lvl;
      fsync_o <= ~nslot[SLOT_W-1];
    end else begin
      dcnt <= dcnt + 1'b1;
      if (dcnt == rise_pt) sclk_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ssp_slave_align.sv
module ssp_slave_align #(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd,
  input  logic              en,
  input  logic              left_lvl,
  input  logic              sclk_i,
  input  logic              lrck_i,
  input  logic              fsync_i,
  output logic              tick,
  output logic [SLOT_W:0]   nslot,
  output logic              fsync_ok
);
  logic sclk_m, sclk_s, sclk_d;
  logic lrck_m, lrck_s, lrck_last;
  logic fsync_m, fsync_s;
  logic [SLOT_W:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_m  <= 1'b0; sclk_s  <= 1'b0; sclk_d <= 1'b0;
      lrck_m  <= 1'b0; lrck_s  <= 1'b0;
      fsync_m <= 1'b0; fsync_s <= 1'b0;
    end else begin
      sclk_m  <= sclk_i;  sclk_s  <= sclk_m;  sclk_d <= sclk_s;
      lrck_m  <= lrck_i;  lrck_s  <= lrck_m;
      fsync_m <= fsync_i; fsync_s <= fsync_m;
    end
  end

  // falling bit clock seen in the system clock domain
  assign tick     = en && !pd && !rst && sclk_d && !sclk_s;
  assign fsync_ok = fsync_s;
  // a frame-clock change restarts the count at slot 0 of its half
  assign nslot    = (lrck_s != lrck_last) ? {lrck_s != left_lvl, {SLOT_W{1'b0}}}
                                          : bcnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || pd || !en) begin
      bcnt      <= '1;
      lrck_last <= left_lvl;
    end else if (tick) begin
      bcnt      <= nslot;
      lrck_last <= lrck_s;
    end
  end
endmodule

// File: rtl/ssp_sample_buf.sv
module ssp_sample_buf #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_left,
  input  logic [W-1:0] s_right,
  input  logic         take,
  output logic [W-1:0] left_next,
  output logic [W-1:0] right_cur
);
  logic [W-1:0] pend_l, pend_r, cur_l, cur_r;
  logic         full;

  assign s_ready   = ~full;
  assign left_next = full ? pend_l : cur_l;
  assign right_cur = cur_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      full   <= 1'b0;
      pend_l <= '0; pend_r <= '0;
      cur_l  <= '0; cur_r  <= '0;
    end else begin
      if (take && full) begin
        cur_l <= pend_l;
        cur_r <= pend_r;
        full  <= 1'b0;
      end else if (s_valid && !full) begin
        pend_l <= s_left;
        pend_r <= s_right;
        full   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssp_serializer.sv
module ssp_serializer #(
  parameter int W      = 20,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd,
  input  logic              tick,
  input  logic [SLOT_W-1:0] slot,
  input  logic              delay_one,
  input  logic              gate,
  input  logic [W-1:0]      word,
  output logic              sdata
);
  localparam int LW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic [LW-1:0] left_cnt;

  always_ff @(posedge clk) begin
    if (rst || pd) begin
      sdata    <= 1'b0;
      shreg    <= '0;
      left_cnt <= '0;
    end else if (tick) begin
      if (slot == '0) begin
        if (delay_one || !gate) begin
          sdata    <= 1'b0;
          shreg    <= word;
          left_cnt <= LW'(W);
        end else begin
          sdata    <= word[W-1];
          shreg    <= word << 1;
          left_cnt <= LW'(W - 1);
        end
      end else if (gate && left_cnt != '0) begin
        sdata    <= shreg[W-1];
        shreg    <= shreg << 1;
        left_cnt <= left_cnt - 1'b1;
      end else begin
        sdata <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stereo_ser_port.sv
module stereo_ser_port #(
  parameter int SAMPLE_W = 20,
  parameter int SLOT_W   = 5,
  parameter int DIV_LO   = 4,
  parameter int DIV_HI   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pwr_dn,
  input  logic [1:0]          mode_sel,
  input  logic                ratio_sel,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  input  logic                sclk_in,
  input  logic                lrck_in,
  input  logic                fsync_in,
  output logic                sclk_out,
  output logic                lrck_out,
  output logic                fsync_out,
  output logic                sdata
);
  import ssp_pkg::*;

  logic              master, left_lvl, msbj;
  logic              m_tick, s_tick, tick, s_fsync_ok, gate, frame_start;
  logic [SLOT_W:0]   m_nslot, s_nslot, nslot;
  logic [SAMPLE_W-1:0] left_next, right_cur, word;

  assign master   = mode_sel[MODE_MASTER_BIT];
  assign left_lvl = left_level(mode_sel);
  assign msbj     = is_msb_just(mode_sel);

  ssp_master_gen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .SLOT_W(SLOT_W)) u_mgen (
    .clk(clk), .rst(rst), .pd(pwr_dn), .en(master), .ratio_hi(ratio_sel),
    .left_lvl(left_lvl), .tick(m_tick), .nslot(m_nslot),
    .sclk_o(sclk_out), .lrck_o(lrck_out), .fsync_o(fsync_out)
  );

  ssp_slave_align #(.SLOT_W(SLOT_W)) u_salign (
    .clk(clk), .rst(rst), .pd(pwr_dn), .en(~master), .left_lvl(left_lvl),
    .sclk_i(sclk_in), .lrck_i(lrck_in), .fsync_i(fsync_in),
    .tick(s_tick), .nslot(s_nslot), .fsync_ok(s_fsync_ok)
  );

  assign tick        = master ? m_tick  : s_tick;
  assign nslot       = master ? m_nslot : s_nslot;
  assign frame_start = tick && (nslot == '0);
  assign gate        = msbj ? s_fsync_ok : 1'b1;
  assign word        = nslot[SLOT_W] ? right_cur : left_next;

  ssp_sample_buf #(.W(SAMPLE_W)) u_buf (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .take(frame_start),
    .left_next(left_next), .right_cur(right_cur)
  );

  ssp_serializer #(.W(SAMPLE_W), .SLOT_W(SLOT_W)) u_ser (
    .clk(clk), .rst(rst), .pd(pwr_dn), .tick(tick),
    .slot(nslot[SLOT_W-1:0]), .delay_one(~msbj), .gate(gate),
    .word(word), .sdata(sdata)
  );
endmodule

// File: rtl/stereo_ser_port_chk.sv
module stereo_ser_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_dn,
  input logic [1:0] mode_sel,
  input logic       s_valid,
  input logic       s_ready,
  input logic       sclk_out,
  input logic       lrck_out,
  input logic       fsync_out,
  input logic       sdata
);
  // R8: power-down quiets data, bit clock and strobe
  p_pd_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> (!sdata && !sclk_out && !fsync_out));

  // R8: master frame clock rests at the left level in power-down
  p_pd_lrck_rest_r8: assert property (@(posedge clk) disable iff (rst)
    (pwr_dn && mode_sel[0]) |=> (lrck_out == !$past(mode_sel[1])));

  // R7: generated clock outputs stay low in slave mode
  p_slave_outs_low_r7: assert property (@(posedge clk) disable iff (rst)
    !mode_sel[0] |=> (!sclk_out && !lrck_out && !fsync_out));

  // R9: an accepted pair fills the holding register
  p_accept_fills_r9: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  // R1: master data changes only together with a bit-clock fall
  p_data_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[0] && $past(mode_sel[0]) && (mode_sel == $past(mode_sel)) &&
     !pwr_dn && !$past(pwr_dn) && (sdata != $past(sdata))) |-> $fell(sclk_out));

  // R1: master frame clock changes only together with a bit-clock fall
  p_lrck_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[0] && $past(mode_sel[0]) && (mode_sel == $past(mode_sel)) &&
     !pwr_dn && !$past(pwr_dn) && (lrck_out != $past(lrck_out))) |-> $fell(sclk_out));
endmodule

bind stereo_ser_port stereo_ser_port_chk u_chk (
  .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .mode_sel(mode_sel),
  .s_valid(s_valid), .s_ready(s_ready), .sclk_out(sclk_out),
  .lrck_out(lrck_out), .fsync_out(fsync_out), .sdata(sdata)
);

// File: tb/stereo_ser_port_test.sv
module stereo_ser_port_test;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rst, pwr_dn, ratio_sel, s_valid, sclk_in, lrck_in, fsync_in;
  logic [1:0] mode_sel;
  logic [W-1:0] s_left, s_right;
  logic s_ready, sclk_out, lrck_out, fsync_out, sdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic prev_sclk = 1'b0;

  always #2 clk = ~clk;

  stereo_ser_port uut (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .mode_sel(mode_sel),
    .ratio_sel(ratio_sel), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .sclk_in(sclk_in),
    .lrck_in(lrck_in), .fsync_in(fsync_in), .sclk_out(sclk_out),
    .lrck_out(lrck_out), .fsync_out(fsync_out), .sdata(sdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_i2s(input logic [W-1:0] l, input logic [W-1:0] r);
    logic [63:0] v = '0;
    for (int s = 0; s < 64; s++) begin
      int k = s % 32;
      logic [W-1:0] w = (s < 32) ? l : r;
      if (k >= 1 && k <= W) v[s] = w[W-k];
    end
    return v;
  endfunction

  function automatic logic [63:0] exp_msbj(input logic [W-1:0] l, input logic [W-1:0] r,
                                           input logic [63:0] mask);
    logic [63:0] v = '0;
    int p = 0;
    for (int s = 0; s < 64; s++) begin
      logic [W-1:0] w = (s < 32) ? l : r;
      if (s % 32 == 0) p = 0;
      if (mask[s] && p < W) begin
        v[s] = w[W-1-p];
        p++;
      end
    end
    return v;
  endfunction

  task automatic do_reset(input logic [1:0] mode, input logic ratio);
    @(negedge clk);
    rst = 1'b1; pwr_dn = 1'b0; mode_sel = mode; ratio_sel = ratio;
    s_valid = 1'b0; sclk_in = 1'b0; lrck_in = ~mode[1]; fsync_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    prev_sclk = 1'b0;
  endtask

  task automatic push(input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    s_valid = 1'b1; s_left = l; s_right = r;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    // R9: holding register now full
    chk(s_ready == 1'b0, "R9", "ready after accept", 64'(s_ready), 64'd0);
  endtask

  task automatic wait_mfall(output int gap);
    bit fell;
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
      fell = prev_sclk && !sclk_out;
      prev_sclk = sclk_out;
    end while (!fell && gap < 1000);
  endtask

  // capture one master frame beginning at a right-to-left frame-clock change
  task automatic capture_master(input logic lft, input int div, output logic [63:0] bits);
    int g, bad_gap, bad_lr, bad_fs;
    logic prev_l;
    bad_gap = 0; bad_lr = 0; bad_fs = 0;
    prev_l = lrck_out;
    forever begin
      wait_mfall(g);
      if (lrck_out == lft && prev_l != lft) break;
      prev_l = lrck_out;
    end
    for (int s = 0; s < 64; s++) begin
      if (s > 0) begin
        wait_mfall(g);
        if (g != div) bad_gap++;
      end
      bits[s] = sdata;
      if (lrck_out != ((s < 32) ? lft : ~lft)) bad_lr++;
      if (fsync_out != ((s % 32) < 16)) bad_fs++;
    end
    chk(bad_gap == 0, "R1", "bit clock period errors", 64'(bad_gap), 64'd0);
    chk(bad_lr == 0, "R2", "frame clock slot errors", 64'(bad_lr), 64'd0);
    chk(bad_fs == 0, "R2", "strobe slot errors", 64'(bad_fs), 64'd0);
  endtask

  // drive slot-by-slot slave stimulus; sample data late in each slot
  task automatic slave_slots(input int first, input int count, input logic lft,
                             input logic [63:0] mask, output logic [63:0] bits);
    bits = '0;
    for (int s = first; s < first + count; s++) begin
      @(negedge clk);
      sclk_in = 1'b0;
      lrck_in = (s < 32) ? lft : ~lft;
      fsync_in = mask[s];
      repeat (4) @(negedge clk);
      sclk_in = 1'b1;
      repeat (4) @(negedge clk);
      bits[s] = sdata;
    end
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst = 1'b1; pwr_dn = 1'b0; mode_sel = 2'b01; ratio_sel = 1'b0;
    s_valid = 1'b0; sclk_in = 1'b0; lrck_in = 1'b0; fsync_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(sdata == 0 && sclk_out == 0 && fsync_out == 0, "R10", "rest outputs",
        64'({sdata, sclk_out, fsync_out}), 64'd0);
    chk(s_ready == 1, "R10", "ready in reset", 64'(s_ready), 64'd1);
    chk(lrck_out == 1, "R10", "frame clock rest", 64'(lrck_out), 64'd1);
    rst = 1'b0;
  endtask

  task automatic t_master_256;
    logic [63:0] bits;
    do_reset(2'b01, 1'b0);
    push(20'hA5C3F, 20'h1234B);
    capture_master(1'b1, 4, bits);
    chk(bits == exp_i2s(20'hA5C3F, 20'h1234B), "R4", "master frame A", bits,
        exp_i2s(20'hA5C3F, 20'h1234B));
    capture_master(1'b1, 4, bits);
    chk(bits == exp_i2s(20'hA5C3F, 20'h1234B), "R9", "repeated pair", bits,
        exp_i2s(20'hA5C3F, 20'h1234B));
    push(20'h80001, 20'h7FFFE);
    capture_master(1'b1, 4, bits);
    capture_master(1'b1, 4, bits);
    chk(bits == exp_i2s(20'h80001, 20'h7FFFE), "R9", "new pair taken", bits,
        exp_i2s(20'h80001, 20'h7FFFE));
  endtask

  task automatic t_master_384;
    logic [63:0] bits;
    do_reset(2'b11, 1'b1);
    push(20'h0F0F0, 20'hFFFFF);
    capture_master(1'b0, 6, bits);
    chk(bits == exp_i2s(20'h0F0F0, 20'hFFFFF), "R3", "low-left frame", bits,
        exp_i2s(20'h0F0F0, 20'hFFFFF));
  endtask

  task automatic t_power_down(input logic [1:0] mode);
    int g;
    logic lft = ~mode[1];
    do_reset(mode, 1'b0);
    push(20'h3C3C3, 20'h5A5A5);
    repeat (37) @(negedge clk);
    pwr_dn = 1'b1;
    @(negedge clk);
    chk(sdata == 0 && sclk_out == 0 && fsync_out == 0, "R8", "quiet in power-down",
        64'({sdata, sclk_out, fsync_out}), 64'd0);
    chk(lrck_out == lft, "R8", "frame clock rest", 64'(lrck_out), 64'(lft));
    repeat (20) @(negedge clk);
    chk(sclk_out == 0 && sdata == 0, "R8", "still quiet", 64'({sclk_out, sdata}), 64'd0);
    pwr_dn = 1'b0;
    prev_sclk = 1'b0;
    wait_mfall(g);
    chk(g == 4, "R8", "cycles to first fall", 64'(g), 64'd4);
    chk(lrck_out == lft, "R8", "restart on left half", 64'(lrck_out), 64'(lft));
  endtask

  task automatic t_slave_i2s;
    logic [63:0] bits;
    do_reset(2'b10, 1'b0);
    push(20'hC0FFE, 20'h0BEEF);
    slave_slots(0, 64, 1'b0, 64'hA5A5_3C3C_0F0F_9696, bits);
    slave_slots(0, 64, 1'b0, 64'h5A5A_C3C3_F0F0_6969, bits);
    chk(bits == exp_i2s(20'hC0FFE, 20'h0BEEF), "R6", "slave frame, strobe ignored",
        bits, exp_i2s(20'hC0FFE, 20'h0BEEF));
    chk(sclk_out == 0 && lrck_out == 0 && fsync_out == 0, "R7", "outputs held low",
        64'({sclk_out, lrck_out, fsync_out}), 64'd0);
  endtask

  task automatic t_slave_realign;
    logic [63:0] bits;
    do_reset(2'b10, 1'b0);
    push(20'h6789A, 20'hEDCBA);
    // partial frame on the right channel level to misplace the count
    slave_slots(40, 13, 1'b0, '1, bits);
    slave_slots(0, 64, 1'b0, '1, bits);
    chk(bits == exp_i2s(20'h6789A, 20'hEDCBA), "R6", "realigned frame", bits,
        exp_i2s(20'h6789A, 20'hEDCBA));
  endtask

  task automatic t_slave_msbj;
    logic [63:0] bits, mask, e;
    mask = '1;
    mask[10] = 1'b0; mask[11] = 1'b0; mask[42] = 1'b0; mask[43] = 1'b0;
    do_reset(2'b00, 1'b0);
    push(20'hB4E1D, 20'h2C6A9);
    slave_slots(0, 64, 1'b1, mask, bits);
    slave_slots(0, 64, 1'b1, mask, bits);
    e = exp_msbj(20'hB4E1D, 20'h2C6A9, mask);
    chk(bits == e, "R5", "gated MSB-justified frame", bits, e);
    mask = '1;
    slave_slots(0, 64, 1'b1, mask, bits);
    e = exp_msbj(20'hB4E1D, 20'h2C6A9, mask);
    chk(bits == e, "R5", "ungated MSB-justified frame", bits, e);
  endtask

  initial begin
    t_reset_state();
    t_master_256();
    t_master_384();
    t_power_down(2'b01);
    t_power_down(2'b11);
    t_slave_i2s();
    t_slave_realign();
    t_slave_msbj();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule